// File: doc/BRIEF.md
# Shared-Tap Differentiator, Hilbert and Half-Band FIR

This block is a streaming FIR engine. It takes one signed sample stream and returns three filtered streams on the same cycle. The first is a wideband differentiator, the second a Hilbert transformer and the third a half-band lowpass filter. All three read from one tapped delay line. One table of coefficient magnitudes, one entry per tap offset k from 1 to (N-1)/2, serves all of them. The table holds 1/k, quantized to a fixed-point constant.

For each offset k, the block builds two values from the pair of taps that sit k places either side of the centre: their difference and their sum. It multiplies each value by the shared constant for k. The differentiator adds up all the difference products with alternating signs. The Hilbert output reuses the odd-k difference products with their sign reversed. The half-band output adds up the odd-k sum products with alternating signs, plus the centre sample multiplied by π/2. A parameter can remove the half-band path completely, and its output then stays at zero. Outputs carry full precision, with enough guard bits that full-scale input can never overflow.

Top module: `shtap_fir`

## Requirements
- R1: Each accepted sample (in_valid high at a rising edge) produces exactly one out_valid pulse, registered at the third rising edge after the accepting edge. The three outputs update together under that one strobe.
- R2: Let c_k = round(2^FRAC / k) and let t[n] be the sample accepted n strobes ago. Then dd_out = Σ_{k=1..M} (-1)^k·c_k·(t[M+k] − t[M−k]), where M = (N_TAPS−1)/2. The differentiator has no centre term.
- R3: ht_out = Σ over odd k of c_k·(t[M+k] − t[M−k]). Even offsets and the centre contribute nothing.
- R4: hb_out = Σ over odd k of (−1)^((k−1)/2)·c_k·(t[M+k] + t[M−k]), plus P·t[M], where P = round(π/2·2^FRAC) (25736 for FRAC = 14). For an input that is a single unit sample, each output reproduces its coefficient sequence exactly, one strobe at a time.
- R5: Inputs at full scale (−32768 and 32767 for a 16-bit input), in any sign pattern, give exact results with no wrap. Outputs are DW+CW+clog2(N_TAPS)+2 bits wide.
- R6: Synchronous active-low reset clears the delay line, the pipeline and all outputs. After reset, outputs read zero and no earlier sample affects a later result.
- R7: With HB_EN = 0, hb_out stays zero, and dd_out and ht_out still follow R2 and R3.
- R8: While in_valid is low, the delay line does not move. Between strobes, all three outputs hold their last values.
- R9: The R1–R4 relations hold for any odd N_TAPS of 3 or more. The latency stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Common strobe for the three results |
| dd_out | output | OW | Differentiator result, signed |
| ht_out | output | OW | Hilbert transformer result, signed |
| hb_out | output | OW | Half-band result, signed; zero when HB_EN = 0 |

## Verification
The bench builds two copies that share one stimulus stream. One uses the default N_TAPS = 15 with the half-band path present. The other uses N_TAPS = 7 with HB_EN = 0. The short copy shows that the offset-to-sign mapping does not depend on length, and it covers the removed half-band path. The long copy reaches offset 7, where every sign alternation and the widest guard-bit demand appear. Full-scale steps, alternating full-scale patterns and gapped strobes push both copies through their worst-case sums and their hold behaviour.

// File: rtl/shtap_pkg.sv
// Package: shared coefficient helpers for the shared-tap FIR.
// Assumes FRAC <= CW-2 so that 1.0 and pi/2 fit as positive signed constants.
package shtap_pkg;

    // Quantized magnitude 1/k with FRAC fractional bits, rounded to nearest.
    function automatic longint inv_coef(input int k, input int frac);
        longint one;
        one = longint'(1) << frac;
        return (one + longint'(k / 2)) / longint'(k);
    endfunction

    // Quantized pi/2 with FRAC fractional bits (102944 = round(pi/2 * 2^16)).
    function automatic longint half_pi_coef(input int frac);
        return ((longint'(102944) << frac) + longint'(32768)) >>> 16;
    endfunction

endpackage

// File: rtl/shtap_delay_line.sv
// Module: shtap_delay_line
// Holds the last N_TAPS accepted samples. taps[0] holds the newest.
// Shifts only on in_valid. tap_vld marks the cycle after an accepted sample.
module shtap_delay_line #(
    parameter int N_TAPS = 15,
    parameter int DW     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic signed [DW-1:0]         in_data,
    output logic [N_TAPS-1:0][DW-1:0]    taps,
    output logic                         tap_vld
);

    // Shift a new sample in on each strobe; mark the update for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps    <= '0;
            tap_vld <= 1'b0;
        end else begin
            tap_vld <= in_valid;
            if (in_valid) begin
                taps <= {taps[N_TAPS-2:0], in_data};
            end
        end
    end

    // R1: every strobe is followed by a tap-valid pulse.
    p_tap_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> tap_vld);

    // R1: no tap-valid pulse without a strobe.
    p_tap_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !tap_vld);

    // R1: the new sample enters at tap 0 and the old tap 0 moves to tap 1.
    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taps[0] == $past(in_data)) && (taps[1] == $past(taps[0])));

    // R8: the delay line does not move without a strobe.
    p_hold_taps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(taps));

endmodule

// File: rtl/shtap_pair_mult.sv
// Module: shtap_pair_mult
// For each offset k, forms the difference and sum of the mirrored taps (stage 1)
// and multiplies them by the shared constant 1/k (stage 2).
// Sums are formed only at odd k, and only when HB_EN is set.
// The centre tap multiplied by pi/2 is produced here too.
// Assumes N_TAPS is odd and at least 3.
module shtap_pair_mult
    import shtap_pkg::*;
#(
    parameter int N_TAPS = 15,
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int FRAC   = 14,
    parameter int HB_EN  = 1,
    parameter int PW     = DW + 1 + CW,
    localparam int M     = (N_TAPS - 1) / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_TAPS-1:0][DW-1:0]  taps,
    input  logic                       tap_vld,
    output logic [M-1:0][PW-1:0]       prod_d,
    output logic [M-1:0][PW-1:0]       prod_s,
    output logic signed [PW-1:0]       prod_c,
    output logic                       prod_vld
);

    localparam int SW = DW + 1;

    logic pre_vld;

    // Carry the sample strobe through the pre-add and multiply stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_vld  <= 1'b0;
            prod_vld <= 1'b0;
        end else begin
            pre_vld  <= tap_vld;
            prod_vld <= pre_vld;
        end
    end

    for (genvar k = 1; k <= M; k++) begin : g_pair
        localparam logic signed [PW-1:0] C_K = PW'(inv_coef(k, FRAC));

        logic signed [SW-1:0] near_x;
        logic signed [SW-1:0] far_x;
        logic signed [SW-1:0] diff_q;
        logic signed [PW-1:0] pd_q;

        assign near_x = SW'($signed(taps[M-k]));
        assign far_x  = SW'($signed(taps[M+k]));

        // Stage 1: difference of the mirrored taps, used by all odd-symmetric outputs.
        always_ff @(posedge clk) begin
            if (!rst_n)       diff_q <= '0;
            else if (tap_vld) diff_q <= near_x - far_x;
        end

        // Stage 2: scale the difference by the shared constant for this offset.
        always_ff @(posedge clk) begin
            if (!rst_n)       pd_q <= '0;
            else if (pre_vld) pd_q <= PW'(diff_q) * C_K;
        end

        assign prod_d[k-1] = pd_q;

        if (HB_EN != 0 && (k % 2) == 1) begin : g_sum
            logic signed [SW-1:0] sum_q;
            logic signed [PW-1:0] ps_q;

            // Stage 1: sum of the mirrored taps for the even-symmetric half-band.
            always_ff @(posedge clk) begin
                if (!rst_n)       sum_q <= '0;
                else if (tap_vld) sum_q <= near_x + far_x;
            end

            // Stage 2: scale the sum by the same shared constant.
            always_ff @(posedge clk) begin
                if (!rst_n)       ps_q <= '0;
                else if (pre_vld) ps_q <= PW'(sum_q) * C_K;
            end

            assign prod_s[k-1] = ps_q;
        end else begin : g_nosum
            assign prod_s[k-1] = '0;
        end
    end

    if (HB_EN != 0) begin : g_mid
        localparam logic signed [PW-1:0] C_MID = PW'(half_pi_coef(FRAC));

        logic signed [DW-1:0] mid_q;
        logic signed [PW-1:0] pc_q;

        // Stage 1: capture the centre tap to match pre-add timing.
        always_ff @(posedge clk) begin
            if (!rst_n)       mid_q <= '0;
            else if (tap_vld) mid_q <= $signed(taps[M]);
        end

        // Stage 2: scale the centre tap by pi/2.
        always_ff @(posedge clk) begin
            if (!rst_n)       pc_q <= '0;
            else if (pre_vld) pc_q <= PW'(mid_q) * C_MID;
        end

        assign prod_c = pc_q;
    end else begin : g_nomid
        assign prod_c = '0;
    end

    // R1: product strobe follows the pre-add strobe by one cycle.
    p_prod_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_vld |=> prod_vld);

endmodule

// File: rtl/shtap_combine.sv
// Module: shtap_combine
// Combines the shared products into three results with per-offset signs.
// The differentiator alternates over all k. The Hilbert output negates the
// odd-k differentiator products. The half-band output alternates over odd-k
// sum products and adds the centre term.
// Assumes OW is wide enough for M full-scale products plus the centre term.
module shtap_combine #(
    parameter int N_TAPS = 15,
    parameter int PW     = 33,
    parameter int OW     = 38,
    parameter int HB_EN  = 1,
    localparam int M     = (N_TAPS - 1) / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [M-1:0][PW-1:0]       prod_d,
    input  logic [M-1:0][PW-1:0]       prod_s,
    input  logic signed [PW-1:0]       prod_c,
    input  logic                       prod_vld,
    output logic                       out_valid,
    output logic signed [OW-1:0]       dd_out,
    output logic signed [OW-1:0]       ht_out,
    output logic signed [OW-1:0]       hb_out
);

    logic signed [OW-1:0] dd_sum;
    logic signed [OW-1:0] ht_sum;
    logic signed [OW-1:0] hb_sum;

    // Signed accumulation of the shared products for all three outputs.
    always_comb begin
        logic signed [OW-1:0] d_term;
        logic signed [OW-1:0] s_term;
        dd_sum = '0;
        ht_sum = '0;
        hb_sum = OW'(prod_c);
        for (int k = 1; k <= M; k++) begin
            d_term = OW'($signed(prod_d[k-1]));
            s_term = OW'($signed(prod_s[k-1]));
            if ((k % 2) == 1) begin
                dd_sum = dd_sum + d_term;
                ht_sum = ht_sum - d_term;
                if ((((k - 1) / 2) % 2) == 0) hb_sum = hb_sum + s_term;
                else                          hb_sum = hb_sum - s_term;
            end else begin
                dd_sum = dd_sum - d_term;
            end
        end
    end

    // Register the differentiator and Hilbert results and the common strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dd_out    <= '0;
            ht_out    <= '0;
        end else begin
            out_valid <= prod_vld;
            if (prod_vld) begin
                dd_out <= dd_sum;
                ht_out <= ht_sum;
            end
        end
    end

    if (HB_EN != 0) begin : g_hb
        // Register the half-band result on the same strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)        hb_out <= '0;
            else if (prod_vld) hb_out <= hb_sum;
        end
    end else begin : g_nohb
        assign hb_out = '0;
    end

    // R8: all outputs hold between strobes.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> ($stable(dd_out) && $stable(ht_out) && $stable(hb_out)));

    // R1: the output strobe follows the product strobe by one cycle.
    p_out_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |=> out_valid);

endmodule

// File: rtl/shtap_fir.sv
// Module: shtap_fir (top)
// Differentiator, Hilbert transformer and half-band lowpass computed together
// from one delay line and one table of 1/k constants. Latency: three cycles
// after the accepting edge. Outputs carry full precision.
// Assumes N_TAPS is odd and at least 3, and FRAC <= CW-2.
module shtap_fir #(
    parameter int N_TAPS = 15,
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int FRAC   = 14,
    parameter int HB_EN  = 1,
    localparam int OW    = DW + CW + $clog2(N_TAPS) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [OW-1:0] dd_out,
    output logic signed [OW-1:0] ht_out,
    output logic signed [OW-1:0] hb_out
);

    localparam int M  = (N_TAPS - 1) / 2;
    localparam int PW = DW + 1 + CW;

    logic [N_TAPS-1:0][DW-1:0] taps;
    logic                      tap_vld;
    logic [M-1:0][PW-1:0]      prod_d;
    logic [M-1:0][PW-1:0]      prod_s;
    logic signed [PW-1:0]      prod_c;
    logic                      prod_vld;

    shtap_delay_line #(.N_TAPS(N_TAPS), .DW(DW)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .taps     (taps),
        .tap_vld  (tap_vld)
    );

    shtap_pair_mult #(
        .N_TAPS(N_TAPS), .DW(DW), .CW(CW), .FRAC(FRAC), .HB_EN(HB_EN), .PW(PW)
    ) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .taps     (taps),
        .tap_vld  (tap_vld),
        .prod_d   (prod_d),
        .prod_s   (prod_s),
        .prod_c   (prod_c),
        .prod_vld (prod_vld)
    );

    shtap_combine #(
        .N_TAPS(N_TAPS), .PW(PW), .OW(OW), .HB_EN(HB_EN)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_d    (prod_d),
        .prod_s    (prod_s),
        .prod_c    (prod_c),
        .prod_vld  (prod_vld),
        .out_valid (out_valid),
        .dd_out    (dd_out),
        .ht_out    (ht_out),
        .hb_out    (hb_out)
    );

    // R7: with the half-band path removed, its output never moves off zero.
    p_hb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (HB_EN == 0) |-> (hb_out == '0));

endmodule

// File: tb/shtap_fir_tb_top.sv
// Scoreboard bench. The driver pushes expected results computed from the
// requirement formulas. Monitors pop and compare them when out_valid appears.
module shtap_fir_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;

    logic ov_a, ov_b;
    logic signed [37:0] dd_a, ht_a, hb_a;
    logic signed [36:0] dd_b, ht_b, hb_b;

    always #2 clk = ~clk;

    shtap_fir dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_a), .dd_out(dd_a), .ht_out(ht_a), .hb_out(hb_a)
    );

    shtap_fir #(.N_TAPS(7), .HB_EN(0)) dut_n7_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_b), .dd_out(dd_b), .ht_out(ht_b), .hb_out(hb_b)
    );

    int n_vec = 0;
    int n_bad = 0;
    longint cyc = 0;
    int hist [15];
    longint qa_dd[$], qa_ht[$], qa_hb[$], qa_cyc[$];
    longint qb_dd[$], qb_ht[$], qb_hb[$];
    string  qa_tag[$], qb_tag[$];
    longint last_dd = 0, last_ht = 0, last_hb = 0;
    string  cur_tag = "R6 reset";
    localparam longint PIQ = longint'(3.14159265358979 * 8192.0);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Expected output of an nt-tap filter of kind 0=dd, 1=ht, 2=hb, from R2-R4.
    function automatic longint model(input int nt, input int kind);
        int m;
        int k;
        int ak;
        longint c;
        longint h;
        longint acc;
        m = (nt - 1) / 2;
        acc = 0;
        for (int n = 0; n < nt; n++) begin
            k  = n - m;
            ak = (k < 0) ? -k : k;
            if (k == 0) begin
                h = (kind == 2) ? PIQ : 0;
            end else begin
                c = (16384 + ak / 2) / ak;
                case (kind)
                    0:       h = (((ak % 2) == 1) ? -c : c) * ((k > 0) ? 1 : -1);
                    1:       h = ((ak % 2) == 1) ? c * ((k > 0) ? 1 : -1) : 0;
                    default: h = ((ak % 2) == 1) ? (((((ak - 1) / 2) % 2) == 1) ? -c : c) : 0;
                endcase
            end
            acc += h * longint'(hist[n]);
        end
        return acc;
    endfunction

    task automatic send(input int x);
        for (int i = 14; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        qa_dd.push_back(model(15, 0));
        qa_ht.push_back(model(15, 1));
        qa_hb.push_back(model(15, 2));
        qa_cyc.push_back(cyc + 4);
        qa_tag.push_back(cur_tag);
        qb_dd.push_back(model(7, 0));
        qb_ht.push_back(model(7, 1));
        qb_hb.push_back(0);
        qb_tag.push_back({"R9 ", cur_tag});
        in_valid = 1'b1;
        in_data  = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 15; i++) hist[i] = 0;
        last_dd = 0; last_ht = 0; last_hb = 0;
        rst_n = 1'b1;
        // R6: state right after reset
        check("R6", "out_valid", longint'(ov_a), 0);
        check("R6", "dd", dd_a, 0);
        check("R6", "ht", ht_a, 0);
        check("R6", "hb", hb_a, 0);
        check("R6", "n7 out_valid", longint'(ov_b), 0);
    endtask

    // Monitor for the 15-tap copy: compare values and latency, and check hold when idle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ov_a) begin
                if (qa_dd.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R1 unexpected out_valid: got 1 expected 0");
                end else begin
                    string t;
                    longint e_dd, e_ht, e_hb;
                    t = qa_tag.pop_front();
                    e_dd = qa_dd.pop_front();
                    e_ht = qa_ht.pop_front();
                    e_hb = qa_hb.pop_front();
                    check(t, "dd R2", dd_a, e_dd);
                    check(t, "ht R3", ht_a, e_ht);
                    check(t, "hb R4", hb_a, e_hb);
                    check(t, "R1 latency cycle", cyc, qa_cyc.pop_front());
                    last_dd = e_dd; last_ht = e_ht; last_hb = e_hb;
                end
            end else begin
                check("R8 hold", "dd", dd_a, last_dd);
                check("R8 hold", "ht", ht_a, last_ht);
                check("R8 hold", "hb", hb_a, last_hb);
            end
        end
    end

    // Monitor for the 7-tap copy without the half-band path.
    always @(negedge clk) begin
        if (rst_n && ov_b) begin
            if (qb_dd.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R9 unexpected n7 out_valid: got 1 expected 0");
            end else begin
                string t;
                t = qb_tag.pop_front();
                check(t, "n7 dd R2", dd_b, qb_dd.pop_front());
                check(t, "n7 ht R3", ht_b, qb_ht.pop_front());
                check(t, "R7 hb disabled", hb_b, qb_hb.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < 15; i++) hist[i] = 0;
        idle(1);
        do_reset();

        cur_tag = "R2 R3 R4 unit impulse";
        send(1);
        idle(20);

        cur_tag = "R4 R5 negative full-scale impulse";
        send(-32768);
        idle(18);

        cur_tag = "R5 positive full-scale step";
        repeat (20) send(32767);

        cur_tag = "R5 alternating full-scale";
        for (int i = 0; i < 20; i++) send(((i % 2) == 1) ? -32768 : 32767);

        cur_tag = "R5 negative full-scale step";
        repeat (20) send(-32768);
        idle(8);

        cur_tag = "R8 gapped random";
        for (int i = 0; i < 30; i++) begin
            send(int'($urandom % 65536) - 32768);
            idle(int'($urandom % 4));
        end

        cur_tag = "R9 random burst";
        for (int i = 0; i < 60; i++) send(int'($urandom % 65536) - 32768);
        idle(10);

        cur_tag = "R6 before reset";
        send(12345);
        send(-777);
        idle(10);
        do_reset();

        cur_tag = "R6 history cleared after reset";
        send(1);
        idle(20);

        // R1: every accepted sample has produced exactly one result
        check("R1", "pending results", longint'(qa_dd.size()), 0);
        check("R1 R9", "n7 pending results", longint'(qb_dd.size()), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule